// File: doc/BRIEF.md
# Shared-Bus SRAM and Flash Interface Controller

This controller connects a 32-bit synchronous host request port to an external memory module. The module has a fast SRAM and a slow flash on one common 32-bit data bus. Each host request carries an address, write data, byte enables, a direction bit and a target bit. The controller turns it into one bus access. It drives an active-low select for each memory, one shared active-low output enable, four active-low byte-lane write strobes for each memory, and a drive enable for the shared data bus. Every strobe width, setup and release interval is a whole number of clock cycles. These counts are derived at elaboration from nanosecond parameters and the clock period.

Requests enter through a valid/ready handshake. The port holds `req_ready` high only while the controller is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A host that sees `req_ready` low must keep its request on the port, and the controller reads nothing from the port during that time. Read data comes back as a single-cycle `rsp_valid` pulse. The response path has no back-pressure, so the host must accept the word in the cycle it appears. A write gives no response.

Consecutive accesses of the same kind (same direction, same memory) are separated by the single idle cycle in which the next request is taken. A change of direction or of target memory inserts extra release cycles. During those cycles both selects are high and nothing drives the bus.

Top module: `dmb_ctrl`

## Requirements
- R1: After reset, both selects, the output enable and all eight write strobes are high (inactive), `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: The SRAM select and the flash select are never low in the same cycle.
- R3: An SRAM read holds `sram_cs_n` and `mem_oe_n` low for exactly 3 cycles at the default parameters. The word on `mem_dq_in` in the last of those cycles appears on `rsp_rdata`, and `rsp_valid` is high for exactly one cycle, the cycle after the last select-low cycle.
- R4: A flash read holds `flash_cs_n` and `mem_oe_n` low for exactly 12 cycles at the default parameters. It returns data with the same one-cycle `rsp_valid` pulse.
- R5: A write keeps the target select low and drives `req_wdata` on `mem_dq_out` with `mem_dq_oe` high for its whole duration, in three phases: first one setup cycle with the strobes high; then a strobe phase of 2 cycles (SRAM) or 10 cycles (flash) at the default parameters; then one hold cycle with the strobes high. The other memory's strobes stay high throughout.
- R6: Write strobe lane i (bit i of each 4-bit strobe bus) goes low in the strobe phase only when byte enable bit i is 1. Lane i carries data bits 8i+7 to 8i. A lane whose enable is 0 is never strobed, so that byte of the memory keeps its old value, and a write with all enables 0 changes nothing.
- R7: `mem_oe_n` is low only during reads, and `mem_dq_oe` is high only during writes.
- R8: When an access differs from the previous accepted access in direction or in target, 2 release cycles (default) follow acceptance. In them both selects and the output enable are high and the bus is not driven. Otherwise the access starts in the cycle right after acceptance.
- R9: `req_ready` is high exactly when no access is in progress. Request inputs presented while `req_ready` is low have no effect. `rsp_valid` pulses only for reads.
- R10: `mem_addr` equals the accepted request address, unchanged, for every cycle in which a select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for data bits 8i+7..8i |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt | input | 1 | 0 = SRAM, 1 = flash |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 32 | Read data |
| sram_cs_n | output | 1 | SRAM select, active low |
| flash_cs_n | output | 1 | Flash select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| sram_we_n | output | 4 | SRAM byte-lane write strobes, active low |
| flash_we_n | output | 4 | Flash byte-lane write strobes, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 32 | Data driven toward the memories |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` on the shared bus |
| mem_dq_in | input | 32 | Data returned by the selected memory |

## Verification
The bench runs directed sequences and then a long seeded random mix of reads and writes. In the random mix, direction, target, address, data, byte enables and busy-time noise all vary. Each access is compared cycle by cycle against a pin pattern the bench computes itself. Same-kind runs against alternating runs tell a missing or spurious release gap apart from a correct one (R8). SRAM against flash accesses tell the two phase lengths apart. Full, partial and empty byte-enable writes, each followed by a read-back, show whether the right lanes were strobed (R6). Requests changed while the port is busy show whether busy-time inputs leak into the access (R9).

// File: rtl/dmb_pkg.sv
package dmb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WHOLD
  } dmb_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dmb_seq.sv
module dmb_seq
  import dmb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int SR_RD  = 3,
  parameter int FL_RD  = 12,
  parameter int SR_WP  = 2,
  parameter int FL_WP  = 10,
  parameter int WHOLD  = 1,
  parameter int TURN   = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_write,
  input  logic              req_tgt,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output dmb_state_e        state,
  output logic              cur_tgt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic [BE_W-1:0]   cur_be
);

  logic [CNT_W-1:0] cnt;
  logic             cur_write;
  logic             last_vld, last_write, last_tgt;
  logic             accept, need_turn, sel_wr, sel_tgt;
  dmb_state_e       first_st;
  logic [CNT_W-1:0] first_cnt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    sel_wr    = (state == ST_IDLE) ? req_write : cur_write;
    sel_tgt   = (state == ST_IDLE) ? req_tgt   : cur_tgt;
    first_st  = sel_wr ? ST_WSETUP : ST_READ;
    first_cnt = sel_wr ? '0 : (sel_tgt ? CNT_W'(FL_RD - 1) : CNT_W'(SR_RD - 1));
    need_turn = last_vld && ((req_write != last_write) || (req_tgt != last_tgt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cur_write  <= 1'b0;
      cur_tgt    <= 1'b0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
      cur_be     <= '0;
      last_vld   <= 1'b0;
      last_write <= 1'b0;
      last_tgt   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_write  <= req_write;
            cur_tgt    <= req_tgt;
            cur_addr   <= req_addr;
            cur_wdata  <= req_wdata;
            cur_be     <= req_be;
            last_vld   <= 1'b1;
            last_write <= req_write;
            last_tgt   <= req_tgt;
            if (need_turn) begin
              state <= ST_TURN;
              cnt   <= CNT_W'(TURN - 1);
            end else begin
              state <= first_st;
              cnt   <= first_cnt;
            end
          end
        end
        ST_TURN: begin
          if (cnt == '0) begin
            state <= first_st;
            cnt   <= first_cnt;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WSETUP: begin
          state <= ST_WSTROBE;
          cnt   <= cur_tgt ? CNT_W'(FL_WP - 1) : CNT_W'(SR_WP - 1);
        end
        ST_WSTROBE: begin
          if (cnt == '0) begin
            state <= ST_WHOLD;
            cnt   <= CNT_W'(WHOLD - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHOLD: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(state) == ST_READ); // R3
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(cur_addr) && $stable(cur_be)); // R9

endmodule

// File: rtl/dmb_pins.sv
module dmb_pins
  import dmb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmb_state_e        state,
  input  logic              cur_tgt,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [BE_W-1:0]   cur_be,
  output logic              sram_cs_n,
  output logic              flash_cs_n,
  output logic              mem_oe_n,
  output logic [BE_W-1:0]   sram_we_n,
  output logic [BE_W-1:0]   flash_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic on_bus, writing, strobing;

  assign on_bus   = (state == ST_READ) || writing;
  assign writing  = (state == ST_WSETUP) || (state == ST_WSTROBE) || (state == ST_WHOLD);
  assign strobing = (state == ST_WSTROBE);

  assign sram_cs_n  = !(on_bus && !cur_tgt);
  assign flash_cs_n = !(on_bus && cur_tgt);
  assign mem_oe_n   = (state != ST_READ);
  assign mem_dq_oe  = writing;
  assign mem_addr   = cur_addr;
  assign mem_dq_out = cur_wdata;

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign sram_we_n[i]  = !(strobing && !cur_tgt && cur_be[i]);
    assign flash_we_n[i] = !(strobing && cur_tgt && cur_be[i]);
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs_n || flash_cs_n); // R2
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R7
  AST_STROBE_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n != '1) |-> (!sram_cs_n && flash_we_n == '1)); // R5
  AST_STROBE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((flash_we_n != '1) || (sram_we_n != '1)) |-> (mem_dq_oe && mem_oe_n)); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sram_cs_n || !flash_cs_n) && $past(!sram_cs_n || !flash_cs_n)) |-> $stable(mem_addr)); // R10

endmodule

// File: rtl/dmb_ctrl.sv
module dmb_ctrl
  import dmb_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 32,
  parameter int CLK_NS       = 10,
  parameter int SRAM_CYC_NS  = 25,
  parameter int SRAM_WP_NS   = 20,
  parameter int SRAM_DS_NS   = 15,
  parameter int FLASH_CYC_NS = 120,
  parameter int FLASH_WP_NS  = 50,
  parameter int FLASH_WPH_NS = 20,
  parameter int FLASH_DS_NS  = 50,
  parameter int RELEASE_NS   = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_be,
  input  logic                 req_write,
  input  logic                 req_tgt,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 sram_cs_n,
  output logic                 flash_cs_n,
  output logic                 mem_oe_n,
  output logic [DATA_W/8-1:0]  sram_we_n,
  output logic [DATA_W/8-1:0]  flash_we_n,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_in
);

  localparam int BE_W  = DATA_W / 8;
  localparam int SR_RD = cdiv(SRAM_CYC_NS, CLK_NS);
  localparam int FL_RD = cdiv(FLASH_CYC_NS, CLK_NS);
  // setup cycle + strobe >= data setup; setup + strobe + hold >= cycle time
  localparam int SR_WP = imax(imax(cdiv(SRAM_WP_NS, CLK_NS), cdiv(SRAM_DS_NS, CLK_NS) - 1), SR_RD - 2);
  localparam int FL_WP = imax(imax(cdiv(FLASH_WP_NS, CLK_NS), cdiv(FLASH_DS_NS, CLK_NS) - 1), FL_RD - 2);
  // hold plus the next setup cycle form the strobe-high gap
  localparam int WHOLD = imax(1, cdiv(FLASH_WPH_NS, CLK_NS) - 1);
  localparam int TURN  = imax(1, cdiv(RELEASE_NS, CLK_NS));
  localparam int CNT_W = $clog2(imax(imax(FL_RD, FL_WP), imax(TURN, WHOLD)) + 1);

  dmb_state_e          state;
  logic                cur_tgt;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DATA_W-1:0]   cur_wdata;
  logic [BE_W-1:0]     cur_be;

  dmb_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
    .SR_RD(SR_RD), .FL_RD(FL_RD), .SR_WP(SR_WP), .FL_WP(FL_WP),
    .WHOLD(WHOLD), .TURN(TURN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_write(req_write), .req_tgt(req_tgt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_dq_in(mem_dq_in),
    .state(state), .cur_tgt(cur_tgt), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .cur_be(cur_be)
  );

  dmb_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
  ) u_pins (
    .clk(clk), .rst_n(rst_n),
    .state(state), .cur_tgt(cur_tgt), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .cur_be(cur_be),
    .sram_cs_n(sram_cs_n), .flash_cs_n(flash_cs_n), .mem_oe_n(mem_oe_n),
    .sram_we_n(sram_we_n), .flash_we_n(flash_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && flash_cs_n && !mem_dq_oe)); // R9
  AST_SEL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sram_cs_n) || $fell(flash_cs_n)) |-> $past(sram_cs_n && flash_cs_n)); // R8

endmodule

// File: tb/dmb_ctrl_bench.sv
module dmb_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  // cycle counts fixed by the requirements at default parameters
  localparam int SRD = 3, FRD = 12, SWP = 2, FWP = 10, HOLD = 1, TURN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_write = 1'b0, req_tgt = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sram_cs_n, flash_cs_n, mem_oe_n, mem_dq_oe;
  logic [3:0]  sram_we_n, flash_we_n;
  logic [18:0] mem_addr;
  logic [31:0] mem_dq_out, mem_dq_in;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_s [16], m_f [16], sh_s [16], sh_f [16];
  logic [3:0]  prev_swe = 4'hF, prev_fwe = 4'hF;
  bit          have_prev = 0, p_wr, p_tgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmb_ctrl u_dmb_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_write(req_write), .req_tgt(req_tgt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_cs_n(sram_cs_n), .flash_cs_n(flash_cs_n), .mem_oe_n(mem_oe_n),
    .sram_we_n(sram_we_n), .flash_we_n(flash_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: answers reads, latches bytes on strobe rising edges
  always_comb begin
    if (!sram_cs_n && !mem_oe_n)       mem_dq_in = m_s[mem_addr[3:0]];
    else if (!flash_cs_n && !mem_oe_n) mem_dq_in = m_f[mem_addr[3:0]];
    else                               mem_dq_in = 32'h0BAD_F00D;
  end

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!prev_swe[i] && sram_we_n[i])  m_s[mem_addr[3:0]][8*i +: 8] <= mem_dq_out[8*i +: 8];
      if (!prev_fwe[i] && flash_we_n[i]) m_f[mem_addr[3:0]][8*i +: 8] <= mem_dq_out[8*i +: 8];
    end
    prev_swe <= sram_we_n;
    prev_fwe <= flash_we_n;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] pins(input bit scs, input bit fcs, input bit oe, input bit doe,
                                       input logic [3:0] swe, input logic [3:0] fwe,
                                       input bit rdy, input bit rv);
    return {scs, fcs, oe, doe, swe, fwe, rdy, rv};
  endfunction

  function automatic logic [13:0] seen();
    return {sram_cs_n, flash_cs_n, mem_oe_n, mem_dq_oe, sram_we_n, flash_we_n, req_ready, rsp_valid};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // called just after a negedge with the controller idle
  task automatic run(input bit wr, input bit tgt, input logic [18:0] a, input logic [31:0] d,
                     input logic [3:0] be, input bit noise);
    int nturn, nacc, wp;
    logic [3:0] lanes;
    logic [31:0] expd;
    req_valid = 1'b1; req_write = wr; req_tgt = tgt; req_addr = a; req_wdata = d; req_be = be;
    check("R9 ready when idle", {31'b0, req_ready}, 32'd1);
    nturn = (have_prev && (wr != p_wr || tgt != p_tgt)) ? TURN : 0;
    wp    = tgt ? FWP : SWP;
    nacc  = wr ? (1 + wp + HOLD) : (tgt ? FRD : SRD);
    @(negedge clk);
    if (noise) begin
      req_addr = ~a; req_wdata = ~d; req_be = ~be; req_write = ~wr; req_tgt = ~tgt;
    end else req_valid = 1'b0;
    for (int n = 1; n <= nturn + nacc; n++) begin
      int k = n - nturn;
      if (n <= nturn) begin
        check("R8 release gap", {18'b0, seen()}, {18'b0, pins(1, 1, 1, 0, 4'hF, 4'hF, 0, 0)});
      end else if (!wr) begin
        check(tgt ? "R2 R4 R7 flash read pins" : "R2 R3 R7 sram read pins", {18'b0, seen()},
              {18'b0, pins(tgt, !tgt, 0, 0, 4'hF, 4'hF, 0, 0)});
        check("R10 address", {13'b0, mem_addr}, {13'b0, a});
      end else begin
        lanes = (k >= 2 && k <= 1 + wp) ? ~be : 4'hF;
        check("R2 R5 R6 R7 write pins", {18'b0, seen()},
              {18'b0, pins(tgt, !tgt, 1, 1, tgt ? 4'hF : lanes, tgt ? lanes : 4'hF, 0, 0)});
        check("R5 write data", mem_dq_out, d);
        check("R10 address", {13'b0, mem_addr}, {13'b0, a});
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check("R9 end of access", {18'b0, seen()}, {18'b0, pins(1, 1, 1, 0, 4'hF, 4'hF, 1, !wr)});
    if (!wr) begin
      expd = tgt ? sh_f[a[3:0]] : sh_s[a[3:0]];
      check(tgt ? "R4 read data" : "R3 read data", rsp_rdata, expd);
    end else if (tgt) sh_f[a[3:0]] = merge(sh_f[a[3:0]], d, be);
    else              sh_s[a[3:0]] = merge(sh_s[a[3:0]], d, be);
    have_prev = 1; p_wr = wr; p_tgt = tgt;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      m_s[i] = 32'hA500_0000 + i * 32'h0001_0203; sh_s[i] = m_s[i];
      m_f[i] = 32'h3C00_0000 + i * 32'h0101_0401; sh_f[i] = m_f[i];
    end
    repeat (3) @(negedge clk);
    check("R1 reset pins", {18'b0, seen()}, {18'b0, pins(1, 1, 1, 0, 4'hF, 4'hF, 1, 0)});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {18'b0, seen()}, {18'b0, pins(1, 1, 1, 0, 4'hF, 4'hF, 1, 0)});
    run(0, 0, 19'h3, 32'h0, 4'hF, 0);                // R3
    run(0, 1, 19'h5, 32'h0, 4'hF, 0);                // R4, R8 target switch
    run(1, 1, 19'h5, 32'hDEAD_BEEF, 4'hF, 0);        // R5, R8 direction switch
    run(1, 1, 19'h6, 32'h1234_5678, 4'h0, 0);        // R6 empty enables
    run(1, 0, 19'h2, 32'hCAFE_F00D, 4'b0101, 0);     // R6 partial lanes
    run(0, 0, 19'h2, 32'h0, 4'h0, 0);                // R6 read-back
    run(0, 0, 19'h2, 32'h0, 4'h0, 1);                // R9 busy-time noise
    run(0, 1, 19'h6, 32'h0, 4'h0, 0);                // R6 unchanged word
    run(0, 1, 19'h5, 32'h0, 4'h0, 0);                // R4 full write read-back
    for (int t = 0; t < 250; t++) begin
      run($urandom % 2, $urandom % 2, 19'($urandom), $urandom, 4'($urandom), $urandom % 4 == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule